// File: doc/BRIEF.md
# Fuse Word Programming Sequencer

This block writes one 32-bit word into a one-time-programmable fuse array. It works one bit at a time. A single start pulse captures the target word address, the program data and a packed timing word. The sequencer then pulses a read strobe to fetch the word's current contents. From that readback it builds a mask, so that only bits still unblown and requested as 1 are programmed. It shifts the masked word right with zero fill, starting at the least significant bit. For every 1 it produces a program strobe, bracketed by relax gaps.

After the last bit the block stays busy for a parameterised quiet period. This keeps the array electrically idle before any further access. Completion is signalled by a one-cycle done pulse, in the same cycle that busy drops. Every phase length comes from the software-supplied timing fields, so one netlist can run at any clock rate. Bus decoding and the fuse array itself live outside this block.

Top module: `fuse_prog_seq`

## Requirements
- R1: During and after synchronous reset, busy_o, done_o, arr_rd_o and arr_pg_o are low.
- R2: A start_i seen while idle latches addr_i, data_i and timing_i. start_i and any change on those inputs while busy are ignored. arr_addr_o holds the latched address for the whole operation.
- R3: timing_i holds the program strobe width in bits 11:0, the relax time in bits 15:12 and the read strobe width in bits 21:16. A phase with field value N lasts N+1 cycles.
- R4: The readback comes first: relax cycles, then arr_rd_o high for the read-width phase, then relax cycles. arr_rdata_i is sampled in the last cycle of the read strobe.
- R5: A bit receives a program strobe only if it is 1 in the data and 0 in the readback. After the operation the word equals the old contents OR the data.
- R6: Bits are visited LSB first with arr_bit_o counting 0 to 31. Each bit spends one scan cycle. A bit that is 0 after masking gets no strobe.
- R7: Each programmed bit runs relax cycles, then arr_pg_o high for the program-width phase, then relax cycles. arr_bit_o is stable throughout.
- R8: After the last bit, busy_o stays high for HOLD_CYC further cycles with no strobe.
- R9: done_o is a single-cycle pulse in the cycle busy_o falls.
- R10: arr_rd_o and arr_pg_o are never high together, and neither is high while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| addr_i | input | ADDR_W | Target fuse word address |
| data_i | input | DATA_W | Bits to program (1 = blow) |
| timing_i | input | 22 | Packed timing: program width, relax, read width |
| arr_rdata_i | input | DATA_W | Fuse word returned by the array during the read strobe |
| arr_addr_o | output | ADDR_W | Latched word address to the array |
| arr_rd_o | output | 1 | Array read strobe |
| arr_pg_o | output | 1 | Array program strobe |
| arr_bit_o | output | $clog2(DATA_W) | Bit index being scanned or programmed |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the complete expected waveform of every operation from the timing fields and the array contents it models. It then compares strobes, busy, done, bit index and address on every cycle.

Several corner cases get their own stimulus:
- Words whose target bits are partly or fully blown already. A design that skipped the readback mask would strobe those bits again.
- All-zero data and all-one data at minimum phase widths. Off-by-one phase counters would shift every later edge.
- Distinct values in each timing field. Swapped field positions would show up as wrong strobe widths.
- A second start together with changed inputs in the middle of an operation. A design that re-latched them would move the address or restart the sequence.
- Bit 31 alone. An early exit from the scan would never strobe it.

// File: rtl/fuse_prog_pkg.sv
package fuse_prog_pkg;

  localparam int TIMING_W = 22;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_PRE,
    ST_RD_STB,
    ST_RD_POST,
    ST_SCAN,
    ST_PG_PRE,
    ST_PG_STB,
    ST_PG_POST,
    ST_HOLD
  } seq_state_e;

  // Packed view of the timing word: MSB field first.
  typedef struct packed {
    logic [5:0]  rd_w;   // bits 21:16
    logic [3:0]  relax;  // bits 15:12
    logic [11:0] pg_w;   // bits 11:0
  } fuse_timing_t;

endpackage

// File: rtl/fuse_phase_timer.sv
module fuse_phase_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // A loaded value N gives N+1 cycles before the phase ends.
  assign expired = (cnt_q == '0);

endmodule

// File: rtl/fuse_bit_shifter.sv
module fuse_bit_shifter #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  output logic              lsb,
  output logic [IDX_W-1:0]  idx,
  output logic              last
);

  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= load_val;
      idx_q <= '0;
    end else if (shift) begin
      sh_q  <= {1'b0, sh_q[DATA_W-1:1]};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign lsb  = sh_q[0];
  assign idx  = idx_q;
  assign last = (idx_q == IDX_W'(DATA_W - 1));

endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
  import fuse_prog_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 7,
  parameter int HOLD_CYC = 250,
  localparam int IDX_W   = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [TIMING_W-1:0] timing_i,
  input  logic [DATA_W-1:0]   arr_rdata_i,
  output logic [ADDR_W-1:0]   arr_addr_o,
  output logic                arr_rd_o,
  output logic                arr_pg_o,
  output logic [IDX_W-1:0]    arr_bit_o,
  output logic                busy_o,
  output logic                done_o
);

  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int CNT_W  = (HOLD_W > 12) ? HOLD_W : 12;

  seq_state_e        state_q, state_d;
  fuse_timing_t      tim_q, tim_in;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;

  logic              t_load, t_expired;
  logic [CNT_W-1:0]  t_val;
  logic              sh_load, sh_shift, sh_lsb, sh_last;
  logic [IDX_W-1:0]  sh_idx;

  logic              busy_q, rd_q, pg_q, done_q;

  assign tim_in = fuse_timing_t'(timing_i);
  assign accept = (state_q == ST_IDLE) && start_i;

  fuse_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  fuse_bit_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (sh_load),
    .load_val (data_q & ~arr_rdata_i),
    .shift    (sh_shift),
    .lsb      (sh_lsb),
    .idx      (sh_idx),
    .last     (sh_last)
  );

  always_comb begin
    state_d  = state_q;
    t_load   = 1'b0;
    t_val    = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RD_PRE;
          t_load  = 1'b1;
          t_val   = CNT_W'(tim_in.relax);
        end
      end
      ST_RD_PRE: begin
        if (t_expired) begin
          state_d = ST_RD_STB;
          t_load  = 1'b1;
          t_val   = CNT_W'(tim_q.rd_w);
        end
      end
      ST_RD_STB: begin
        if (t_expired) begin
          state_d = ST_RD_POST;
          t_load  = 1'b1;
          t_val   = CNT_W'(tim_q.relax);
          sh_load = 1'b1;  // capture masked word while the array drives data
        end
      end
      ST_RD_POST: begin
        if (t_expired) state_d = ST_SCAN;
      end
      ST_SCAN: begin
        if (sh_lsb) begin
          state_d = ST_PG_PRE;
          t_load  = 1'b1;
          t_val   = CNT_W'(tim_q.relax);
        end else if (sh_last) begin
          state_d = ST_HOLD;
          t_load  = 1'b1;
          t_val   = CNT_W'(HOLD_CYC - 1);
        end else begin
          sh_shift = 1'b1;
        end
      end
      ST_PG_PRE: begin
        if (t_expired) begin
          state_d = ST_PG_STB;
          t_load  = 1'b1;
          t_val   = CNT_W'(tim_q.pg_w);
        end
      end
      ST_PG_STB: begin
        if (t_expired) begin
          state_d = ST_PG_POST;
          t_load  = 1'b1;
          t_val   = CNT_W'(tim_q.relax);
        end
      end
      ST_PG_POST: begin
        if (t_expired) begin
          if (sh_last) begin
            state_d = ST_HOLD;
            t_load  = 1'b1;
            t_val   = CNT_W'(HOLD_CYC - 1);
          end else begin
            state_d  = ST_SCAN;
            sh_shift = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (t_expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tim_q   <= '0;
      data_q  <= '0;
      addr_q  <= '0;
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      pg_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        tim_q  <= tim_in;
        data_q <= data_i;
        addr_q <= addr_i;
      end
      busy_q <= (state_d != ST_IDLE);
      rd_q   <= (state_d == ST_RD_STB);
      pg_q   <= (state_d == ST_PG_STB);
      done_q <= (state_q == ST_HOLD) && (state_d == ST_IDLE);
    end
  end

  assign arr_addr_o = addr_q;
  assign arr_rd_o   = rd_q;
  assign arr_pg_o   = pg_q;
  assign arr_bit_o  = sh_idx;
  assign busy_o     = busy_q;
  assign done_o     = done_q;

endmodule

// File: rtl/fuse_prog_seq_chk.sv
module fuse_prog_seq_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 7,
  parameter int HOLD_CYC = 250,
  localparam int IDX_W   = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              arr_rd_o,
  input logic              arr_pg_o,
  input logic [IDX_W-1:0]  arr_bit_o,
  input logic              busy_o,
  input logic              done_o
);

  localparam int QW = $clog2(HOLD_CYC + 2) + 1;

  // Cycles since the last strobe of either kind, saturating.
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_q <= '0;
    end else if (arr_rd_o || arr_pg_o) begin
      quiet_q <= '0;
    end else if (quiet_q != {QW{1'b1}}) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(arr_rd_o && arr_pg_o));

  assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (arr_rd_o || arr_pg_o) |-> busy_o);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(arr_addr_o));

  assert_bit_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (arr_pg_o && $past(arr_pg_o)) |-> $stable(arr_bit_o));

  assert_done_fall_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $fell(busy_o));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_holdoff_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (32'(quiet_q) >= HOLD_CYC));

endmodule

bind fuse_prog_seq fuse_prog_seq_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .HOLD_CYC (HOLD_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .arr_addr_o (arr_addr_o),
  .arr_rd_o   (arr_rd_o),
  .arr_pg_o   (arr_pg_o),
  .arr_bit_o  (arr_bit_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/fuse_prog_seq_test.sv
module fuse_prog_seq_test;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 7;
  localparam int HOLD_CYC = 250;
  localparam int IDX_W    = 5;
  localparam int WORDS    = 128;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic              rst;
  logic              start_i;
  logic [ADDR_W-1:0] addr_i;
  logic [DATA_W-1:0] data_i;
  logic [21:0]       timing_i;
  logic [DATA_W-1:0] arr_rdata_i;
  logic [ADDR_W-1:0] arr_addr_o;
  logic              arr_rd_o, arr_pg_o, busy_o, done_o;
  logic [IDX_W-1:0]  arr_bit_o;

  logic [DATA_W-1:0] fuse [WORDS];

  // Array model: data is driven only while the read strobe is high.
  assign arr_rdata_i = arr_rd_o ? fuse[arr_addr_o] : '0;

  fuse_prog_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .HOLD_CYC(HOLD_CYC)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
    .timing_i(timing_i), .arr_rdata_i(arr_rdata_i), .arr_addr_o(arr_addr_o),
    .arr_rd_o(arr_rd_o), .arr_pg_o(arr_pg_o), .arr_bit_o(arr_bit_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct packed {
    logic             busy;
    logic             rd;
    logic             pg;
    logic             done;
    logic             chk;
    logic [IDX_W-1:0] idx;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;

  task automatic push(input int n, input logic b, input logic r, input logic p,
                      input logic d, input logic c, input logic [IDX_W-1:0] i);
    exp_t e;
    e = '{busy: b, rd: r, pg: p, done: d, chk: c, idx: i};
    for (int k = 0; k < n; k++) q.push_back(e);
  endtask

  // Expected waveform from the requirements (R3 field positions, R4..R9 order).
  task automatic build(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                       input logic [21:0] t);
    logic [DATA_W-1:0] m;
    int pw, rl, rw;
    pw = int'(t[11:0]);
    rl = int'(t[15:12]);
    rw = int'(t[21:16]);
    m  = d & ~fuse[a];                               // R5 mask
    push(rl + 1, 1, 0, 0, 0, 0, '0);                 // R4 relax
    push(rw + 1, 1, 1, 0, 0, 0, '0);                 // R4 read strobe
    push(rl + 1, 1, 0, 0, 0, 0, '0);                 // R4 relax
    for (int i = 0; i < DATA_W; i++) begin
      push(1, 1, 0, 0, 0, 1, IDX_W'(i));             // R6 scan cycle
      if (m[i]) begin
        push(rl + 1, 1, 0, 0, 0, 1, IDX_W'(i));      // R7
        push(pw + 1, 1, 0, 1, 0, 1, IDX_W'(i));
        push(rl + 1, 1, 0, 0, 0, 1, IDX_W'(i));
      end
    end
    push(HOLD_CYC, 1, 0, 0, 0, 1, IDX_W'(DATA_W - 1)); // R8
    push(1, 0, 0, 0, 1, 0, '0);                      // R9 done with busy low
    push(1, 0, 0, 0, 0, 0, '0);
  endtask

  task automatic check1(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic cmp(input exp_t e, input logic [ADDR_W-1:0] a);
    check1(busy_o === e.busy, "R8", "busy", 32'(busy_o), 32'(e.busy));
    check1(arr_rd_o === e.rd, "R4", "read strobe", 32'(arr_rd_o), 32'(e.rd));
    check1(arr_pg_o === e.pg, "R7", "program strobe", 32'(arr_pg_o), 32'(e.pg));
    check1(done_o === e.done, "R9", "done", 32'(done_o), 32'(e.done));
    if (e.chk)
      check1(arr_bit_o === e.idx, "R6", "bit index", 32'(arr_bit_o), 32'(e.idx));
    if (e.busy)
      check1(arr_addr_o === a, "R2", "address", 32'(arr_addr_o), 32'(a));
  endtask

  task automatic run_op(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic [21:0] t, input bit disturb);
    logic [DATA_W-1:0] old;
    exp_t e;
    int k;
    old = fuse[a];
    build(a, d, t);
    start_i  = 1'b1;
    addr_i   = a;
    data_i   = d;
    timing_i = t;
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    while (q.size() > 0) begin
      e = q.pop_front();
      cmp(e, a);
      if (arr_pg_o) fuse[arr_addr_o][arr_bit_o] = 1'b1;
      if (disturb && k == 3) begin
        // R2: second start and new inputs while busy must be ignored
        start_i  = 1'b1;
        addr_i   = ~a;
        data_i   = ~d;
        timing_i = '0;
      end else begin
        start_i = 1'b0;
      end
      k++;
      @(negedge clk);
    end
    check1(fuse[a] === (old | d), "R5", "final word", fuse[a], old | d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired: actual busy %0b expected done", busy_o);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) fuse[i] = '0;
    fuse[9]  = 32'h0000_00F0;
    fuse[20] = 32'hFFFF_FFFF;
    rst      = 1'b1;
    start_i  = 1'b0;
    addr_i   = '0;
    data_i   = '0;
    timing_i = '0;
    repeat (3) @(negedge clk);
    check1(!busy_o && !done_o && !arr_rd_o && !arr_pg_o, "R1", "outputs in reset",
           {28'd0, busy_o, done_o, arr_rd_o, arr_pg_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check1(!busy_o && !done_o && !arr_rd_o && !arr_pg_o, "R1", "outputs after reset",
           {28'd0, busy_o, done_o, arr_rd_o, arr_pg_o}, 32'd0);

    run_op(7'd5,  32'h8000_0001, 22'h02_1003, 1'b0); // R6 first and last bit
    run_op(7'd9,  32'h0000_0FF0, 22'h05_3007, 1'b0); // R5 partly blown, R3 distinct fields
    run_op(7'd12, 32'h0000_0000, 22'h02_1003, 1'b0); // R6 nothing to program
    run_op(7'd30, 32'hFFFF_FFFF, 22'h00_0000, 1'b0); // R3 minimum widths
    run_op(7'd20, 32'hA5A5_A5A5, 22'h3F_F00A, 1'b0); // R5 fully blown word
    run_op(7'd40, 32'h0000_0106, 22'h02_1003, 1'b1); // R2 disturbance while busy
    run_op(7'd5,  32'h0000_0003, 22'h01_2002, 1'b0); // R5 bit0 already set
    check1(fuse[41] === '0 && fuse[87] === '0, "R2", "untouched words",
           fuse[41] | fuse[87], 32'd0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule